// File: doc/BRIEF.md
# Direct-Mapped Translation Buffer with Per-Page Privilege Checks

This block translates virtual addresses to physical ones through two small direct-mapped tables. One table serves instruction fetches and the other serves loads and stores. Each entry pairs a match word with a translate word. The match word holds the page tag and a valid flag. The translate word holds the page frame and the permission bits for supervisor and user modes.

Each access presents a virtual address, an access kind and a supervisor flag. In the same cycle the block returns either a physical address with a grant, or a refusal. A refused access is classified at the next clock edge as a buffer miss or a page fault, on the instruction side or the data side. The refused address is captured in a fault-address register, and any outstanding load-linked reservation is dropped.

Software fills the tables through a single write port, one word per cycle. With translation switched off, every address passes straight through and every access is granted.

Top module: `tlb_top`

## Requirements
- R1: The page number is `acc_vaddr[31:13]` and the entry index is its low 6 bits (`acc_vaddr[18:13]`). A hit needs `match[31:13]` of the indexed entry to equal the whole page number. Any difference is a miss, reported as `flt_cause` 1 for a fetch and 2 for a load or store.
- R2: Bit 0 of the match word is the valid flag. When the tag matches but the valid flag is clear, the access is refused as a page fault, not a miss: `flt_cause` 3 for a fetch and 4 for a load or store.
- R3: A fetch (`acc_kind` 2'b00) needs translate bit 1 in supervisor mode and translate bit 0 in user mode. Without that bit it is refused with `flt_cause` 3.
- R4: A load (`acc_kind` 2'b01) needs translate bit 2 in supervisor mode and bit 0 in user mode. A store (`acc_kind` 2'b10, with 2'b11 treated as a store) needs bit 3 in supervisor mode and bit 1 in user mode. Without the needed bit the access is refused with `flt_cause` 4.
- R5: On a grant, `acc_paddr` is `translate[31:13]` followed by `acc_vaddr[12:0]`, in the same cycle as the access.
- R6: A fetch consults only the instruction table, and a load or store consults only the data table. The contents of the other table never change the result.
- R7: A refused access with `acc_valid` high raises `flt_valid` one cycle later, with the cause code given in R1 to R4. In every other cycle `flt_valid` is 0 and `flt_cause` is 0.
- R8: On a refusal, `eear` takes the refused virtual address at the same edge that raises `flt_valid`. Otherwise `eear` holds its value.
- R9: `rsv_valid` is set by `rsv_set` and cleared by a refusal. When both occur in the same cycle, the clear wins.
- R10: With `xlat_en` low, every access is granted with `acc_paddr` equal to `acc_vaddr`, and no fault is raised.
- R11: A write with `wr_en` high stores `wr_data` into the table chosen by `wr_side` (0 = instruction, 1 = data), at entry `wr_idx`, into the word chosen by `wr_word` (0 = match, 1 = translate). A lookup in the same cycle still sees the old contents, and the new contents take effect from the next cycle.
- R12: Reset clears every match word, so every valid flag reads 0. Reset also clears `flt_valid`, `flt_cause`, `eear` and `rsv_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xlat_en | input | 1 | Translation enable |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_kind | input | 2 | 00 fetch, 01 load, 10 or 11 store |
| acc_super | input | 1 | Supervisor mode flag |
| acc_vaddr | input | 32 | Virtual address |
| acc_ok | output | 1 | Access granted (combinational) |
| acc_paddr | output | 32 | Physical address, meaningful when acc_ok is high |
| flt_valid | output | 1 | Fault raised by the previous cycle's access |
| flt_cause | output | 3 | 1 instr miss, 2 data miss, 3 instr page fault, 4 data page fault |
| eear | output | 32 | Last refused virtual address |
| rsv_set | input | 1 | Set the load-linked reservation |
| rsv_valid | output | 1 | Reservation outstanding |
| wr_en | input | 1 | Table write strobe |
| wr_side | input | 1 | 0 instruction table, 1 data table |
| wr_word | input | 1 | 0 match word, 1 translate word |
| wr_idx | input | 6 | Entry index to write |
| wr_data | input | 32 | Word to write |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is a reservation set and a refusal. The sweep asserts `rsv_set` on every access, so whenever the access is refused both events land on the same edge. The bench expects the reservation to read clear after every refused access and set after every granted one.

The second pair is a table write and a lookup of the entry being rewritten. The bench issues both in one cycle. It expects the lookup to see the old tag, and the following cycle to see only the new one.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    typedef enum logic [1:0] {
        KIND_FETCH = 2'b00,
        KIND_LOAD  = 2'b01,
        KIND_STORE = 2'b10
    } acc_kind_e;

    typedef enum logic [1:0] {
        ST_HIT     = 2'd0,
        ST_NOMATCH = 2'd1,
        ST_INVALID = 2'd2,
        ST_DENIED  = 2'd3
    } look_st_e;

    typedef enum logic [2:0] {
        CZ_NONE  = 3'd0,
        CZ_IMISS = 3'd1,
        CZ_DMISS = 3'd2,
        CZ_IPF   = 3'd3,
        CZ_DPF   = 3'd4
    } fault_e;

    // Permission bit positions inside the translate word
    localparam int unsigned PB_U_X = 0;  // instruction table
    localparam int unsigned PB_S_X = 1;
    localparam int unsigned PB_U_R = 0;  // data table
    localparam int unsigned PB_U_W = 1;
    localparam int unsigned PB_S_R = 2;
    localparam int unsigned PB_S_W = 3;

    typedef struct packed {
        logic     ok;
        fault_e   cause;
    } verdict_t;

    function automatic logic perm_ok(input logic [1:0] kind, input logic sup,
                                     input logic [3:0] pb);
        logic r;
        if (kind == KIND_FETCH)
            r = sup ? pb[PB_S_X] : pb[PB_U_X];
        else if (kind == KIND_LOAD)
            r = sup ? pb[PB_S_R] : pb[PB_U_R];
        else
            r = sup ? pb[PB_S_W] : pb[PB_U_W];
        return r;
    endfunction

    function automatic verdict_t classify(input look_st_e st, input logic is_fetch);
        verdict_t v;
        v.ok = (st == ST_HIT);
        case (st)
            ST_HIT:     v.cause = CZ_NONE;
            ST_NOMATCH: v.cause = is_fetch ? CZ_IMISS : CZ_DMISS;
            default:    v.cause = is_fetch ? CZ_IPF : CZ_DPF;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/tlb_array.sv
module tlb_array #(
    parameter int unsigned WORD_W  = 32,
    parameter int unsigned ENTRIES = 64,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic              we_trans,
    input  logic [IDX_W-1:0]  widx,
    input  logic [WORD_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [WORD_W-1:0] rmatch,
    output logic [WORD_W-1:0] rtrans
);
    logic [WORD_W-1:0] mw [ENTRIES];
    logic [WORD_W-1:0] tw [ENTRIES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < int'(ENTRIES); k++) mw[k] <= '0;
        end else if (we && !we_trans) begin
            mw[widx] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (we && we_trans) tw[widx] <= wdata;
    end

    assign rmatch = mw[ridx];
    assign rtrans = tw[ridx];
endmodule

// File: rtl/tlb_lookup.sv
module tlb_lookup
    import tlb_pkg::*;
#(
    parameter int unsigned VA_W  = 32,
    parameter int unsigned OFF_W = 13
) (
    input  logic [VA_W-1:0] vaddr,
    input  logic [1:0]      kind,
    input  logic            sup,
    input  logic [VA_W-1:0] mword,
    input  logic [VA_W-1:0] tword,
    output look_st_e        st,
    output logic [VA_W-1:0] paddr
);
    logic tag_eq;
    assign tag_eq = (mword[VA_W-1:OFF_W] == vaddr[VA_W-1:OFF_W]);

    always_comb begin
        if (!tag_eq)                          st = ST_NOMATCH;
        else if (!mword[0])                   st = ST_INVALID;
        else if (!perm_ok(kind, sup, tword[3:0])) st = ST_DENIED;
        else                                  st = ST_HIT;
    end

    assign paddr = {tword[VA_W-1:OFF_W], vaddr[OFF_W-1:0]};
endmodule

// File: rtl/tlb_top.sv
module tlb_top
    import tlb_pkg::*;
#(
    parameter int unsigned VA_W    = 32,
    parameter int unsigned OFF_W   = 13,
    parameter int unsigned ENTRIES = 64,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              xlat_en,
    input  logic              acc_valid,
    input  logic [1:0]        acc_kind,
    input  logic              acc_super,
    input  logic [VA_W-1:0]   acc_vaddr,
    output logic              acc_ok,
    output logic [VA_W-1:0]   acc_paddr,
    output logic              flt_valid,
    output logic [2:0]        flt_cause,
    output logic [VA_W-1:0]   eear,
    input  logic              rsv_set,
    output logic              rsv_valid,
    input  logic              wr_en,
    input  logic              wr_side,
    input  logic              wr_word,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [VA_W-1:0]   wr_data
);
    localparam int unsigned SIDES = 2;

    logic [IDX_W-1:0] ridx;
    logic [VA_W-1:0]  mw_s [SIDES];
    logic [VA_W-1:0]  tw_s [SIDES];
    logic             is_fetch;
    logic [VA_W-1:0]  mw_sel, tw_sel, xl_paddr;
    look_st_e         st;
    verdict_t         vd;
    logic             refuse;

    assign ridx     = acc_vaddr[OFF_W +: IDX_W];
    assign is_fetch = (acc_kind == KIND_FETCH);

    for (genvar s = 0; s < int'(SIDES); s++) begin : g_side
        tlb_array #(.WORD_W(VA_W), .ENTRIES(ENTRIES)) u_arr (
            .clk      (clk),
            .rst      (rst),
            .we       (wr_en && (wr_side == s[0])),
            .we_trans (wr_word),
            .widx     (wr_idx),
            .wdata    (wr_data),
            .ridx     (ridx),
            .rmatch   (mw_s[s]),
            .rtrans   (tw_s[s])
        );
    end

    assign mw_sel = is_fetch ? mw_s[0] : mw_s[1];
    assign tw_sel = is_fetch ? tw_s[0] : tw_s[1];

    tlb_lookup #(.VA_W(VA_W), .OFF_W(OFF_W)) u_look (
        .vaddr (acc_vaddr),
        .kind  (acc_kind),
        .sup   (acc_super),
        .mword (mw_sel),
        .tword (tw_sel),
        .st    (st),
        .paddr (xl_paddr)
    );

    assign vd        = classify(st, is_fetch);
    assign acc_ok    = xlat_en ? vd.ok : 1'b1;
    assign acc_paddr = xlat_en ? xl_paddr : acc_vaddr;
    assign refuse    = acc_valid && xlat_en && !vd.ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            flt_valid <= 1'b0;
            flt_cause <= CZ_NONE;
            eear      <= '0;
            rsv_valid <= 1'b0;
        end else begin
            flt_valid <= refuse;
            flt_cause <= refuse ? vd.cause : CZ_NONE;
            if (refuse) eear <= acc_vaddr;
            if (refuse)       rsv_valid <= 1'b0;
            else if (rsv_set) rsv_valid <= 1'b1;
        end
    end
endmodule

// File: rtl/tlb_checker.sv
module tlb_checker #(
    parameter int unsigned VA_W  = 32,
    parameter int unsigned OFF_W = 13
) (
    input logic            clk,
    input logic            rst,
    input logic            xlat_en,
    input logic            acc_valid,
    input logic            acc_ok,
    input logic [VA_W-1:0] acc_vaddr,
    input logic [VA_W-1:0] acc_paddr,
    input logic            flt_valid,
    input logic [2:0]      flt_cause,
    input logic [VA_W-1:0] eear,
    input logic            rsv_valid
);
    logic bad;
    assign bad = acc_valid && xlat_en && !acc_ok;

    a_r7_fault_follows: assert property (@(posedge clk) disable iff (rst)
        bad |=> flt_valid);
    a_r7_quiet: assert property (@(posedge clk) disable iff (rst)
        !bad |=> (!flt_valid && flt_cause == 3'd0));
    a_r7_cause_range: assert property (@(posedge clk) disable iff (rst)
        flt_valid |-> (flt_cause >= 3'd1 && flt_cause <= 3'd4));
    a_r8_eear_capture: assert property (@(posedge clk) disable iff (rst)
        bad |=> (eear == $past(acc_vaddr)));
    a_r8_eear_hold: assert property (@(posedge clk) disable iff (rst)
        !bad |=> $stable(eear));
    a_r9_rsv_drop: assert property (@(posedge clk) disable iff (rst)
        bad |=> !rsv_valid);
    a_r5_offset: assert property (@(posedge clk) disable iff (rst)
        acc_ok |-> (acc_paddr[OFF_W-1:0] == acc_vaddr[OFF_W-1:0]));
    a_r10_bypass: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !xlat_en) |-> (acc_ok && acc_paddr == acc_vaddr));
endmodule

bind tlb_top tlb_checker #(.VA_W(VA_W), .OFF_W(OFF_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .xlat_en   (xlat_en),
    .acc_valid (acc_valid),
    .acc_ok    (acc_ok),
    .acc_vaddr (acc_vaddr),
    .acc_paddr (acc_paddr),
    .flt_valid (flt_valid),
    .flt_cause (flt_cause),
    .eear      (eear),
    .rsv_valid (rsv_valid)
);

// File: tb/tb_tlb_top.sv
`timescale 1ns/1ps
module tb_tlb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        xlat_en = 1'b0, acc_valid = 1'b0, acc_super = 1'b0;
    logic [1:0]  acc_kind = 2'b00;
    logic [31:0] acc_vaddr = '0;
    logic        acc_ok, flt_valid, rsv_valid;
    logic [31:0] acc_paddr, eear;
    logic [2:0]  flt_cause;
    logic        rsv_set = 1'b0, wr_en = 1'b0, wr_side = 1'b0, wr_word = 1'b0;
    logic [5:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;

    int total = 0, bad = 0;
    logic [31:0] bm [2][64];
    logic [31:0] bt [2][64];
    logic [31:0] m_eear = '0;
    logic        m_rsv = 1'b0;
    bit          done = 0;

    always #4 clk = ~clk;

    tlb_top dut (.*);

    task automatic chk(input bit cond, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!cond) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input bit side, input bit word, input int idx, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1; wr_side = side; wr_word = word; wr_idx = idx[5:0]; wr_data = d;
        @(negedge clk);
        wr_en = 0;
        if (word) bt[side][idx] = d; else bm[side][idx] = d;
    endtask

    // Expected result from the requirements
    task automatic model(input logic [1:0] kind, input bit sup, input logic [31:0] va,
                         output bit ok, output logic [2:0] cz, output logic [31:0] pa);
        int side, idx, pbit;
        side = (kind == 2'b00) ? 0 : 1;
        idx  = int'(va[18:13]);
        pa   = {bt[side][idx][31:13], va[12:0]};
        if (!xlat_en) begin ok = 1; cz = 0; pa = va; return; end
        if (kind == 2'b00)      pbit = sup ? 1 : 0;
        else if (kind == 2'b01) pbit = sup ? 2 : 0;
        else                    pbit = sup ? 3 : 1;
        if (bm[side][idx][31:13] != va[31:13])  cz = side ? 3'd2 : 3'd1;   // R1
        else if (!bm[side][idx][0])             cz = side ? 3'd4 : 3'd3;   // R2
        else if (!bt[side][idx][pbit])          cz = side ? 3'd4 : 3'd3;   // R3 R4
        else                                    cz = 3'd0;
        ok = (cz == 0);
    endtask

    task automatic acc(input logic [1:0] kind, input bit sup, input logic [31:0] va,
                       input bit setr, input string req);
        bit ok; logic [2:0] cz; logic [31:0] pa;
        model(kind, sup, va, ok, cz, pa);
        @(negedge clk);
        acc_valid = 1; acc_kind = kind; acc_super = sup; acc_vaddr = va; rsv_set = setr;
        #1;
        chk(acc_ok == ok, {req, " grant"}, 32'(acc_ok), 32'(ok));
        if (ok && acc_ok) chk(acc_paddr == pa, {req, " R5 paddr"}, acc_paddr, pa);
        @(negedge clk);
        if (!ok) begin m_eear = va; m_rsv = 0; end
        else if (setr) m_rsv = 1;
        chk(flt_valid == !ok, {req, " R7 flt_valid"}, 32'(flt_valid), 32'(!ok));
        chk(flt_cause == cz, {req, " R7 cause"}, 32'(flt_cause), 32'(cz));
        chk(eear == m_eear, {req, " R8 eear"}, eear, m_eear);
        chk(rsv_valid == m_rsv, {req, " R9 rsv"}, 32'(rsv_valid), 32'(m_rsv));
        acc_valid = 0; rsv_set = 0;
    endtask

    function automatic logic [31:0] mk_match(int side, int i);
        logic [12:0] hi = 13'((i * 37 + 5 + side) % 8192);
        return {hi, 6'(i), 12'd0, 1'((i % 5) != 0)};
    endfunction

    initial begin
        for (int s = 0; s < 2; s++)
            for (int i = 0; i < 64; i++) begin bm[s][i] = '0; bt[s][i] = '0; end
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        // R12 reset state
        chk(flt_valid == 0 && flt_cause == 0, "R12 flags", 32'(flt_valid), 0);
        chk(eear == 0, "R12 eear", eear, 0);
        chk(rsv_valid == 0, "R12 rsv", 32'(rsv_valid), 0);
        xlat_en = 1;
        acc(2'b00, 1, 32'h0000_0005, 0, "R12 R2 ifetch cleared valid");
        acc(2'b01, 0, 32'h0000_0123, 0, "R12 R2 load cleared valid");
        acc(2'b00, 0, 32'h0008_0000, 0, "R12 R1 imiss");
        acc(2'b10, 0, 32'h0008_0044, 1, "R12 R1 dmiss");

        // R11 fill both tables
        for (int s = 0; s < 2; s++)
            for (int i = 0; i < 64; i++) begin
                wr(s[0], 0, i, mk_match(s, i));
                wr(s[0], 1, i, {19'((i * 91 + 3) % 524288), 9'd0,
                                 s ? 4'(i) : {2'b00, 2'((i >> 2) & 3)}});
            end

        // Sweep: R1 R2 R3 R4 R5 R6 R9
        for (int i = 0; i < 64; i++)
            for (int k = 0; k < 3; k++)
                for (int sp = 0; sp < 2; sp++)
                    for (int sel = 0; sel < 3; sel++) begin
                        int side = (k == 0) ? 0 : 1;
                        logic [31:0] m;
                        logic [31:0] va;
                        if (sel == 1) m = mk_match(1 - side, i);        // R6 other table tag
                        else          m = mk_match(side, i);
                        va = {m[31:13], 13'((i * 131) % 8192)};
                        if (sel == 2) va[31:19] = va[31:19] + 13'd1;     // R1 tag mismatch
                        acc(2'(k), sp[0], va, 1, "R1 R2 R3 R4 R6 sweep");
                    end

        // R11 write and lookup in the same cycle
        begin
            bit ok; logic [2:0] cz; logic [31:0] pa;
            logic [31:0] oldva, newm;
            oldva = {mk_match(0, 7)[31:13], 13'h10};
            newm  = mk_match(0, 7) + 32'h0008_0000;
            model(2'b00, 0, oldva, ok, cz, pa);
            @(negedge clk);
            wr_en = 1; wr_side = 0; wr_word = 0; wr_idx = 6'd7; wr_data = newm;
            acc_valid = 1; acc_kind = 2'b00; acc_super = 0; acc_vaddr = oldva;
            #1;
            chk(acc_ok == ok, "R11 same-cycle old view", 32'(acc_ok), 32'(ok));
            @(negedge clk);
            wr_en = 0; acc_valid = 0;
            if (!ok) m_eear = oldva;
            if (!ok) m_rsv = 0;
            bm[0][7] = newm;
            acc(2'b00, 0, oldva, 0, "R11 old tag gone");
            acc(2'b00, 0, {newm[31:13], 13'h10}, 0, "R11 new tag live");
        end

        // R10 pass-through
        xlat_en = 0;
        acc(2'b10, 0, 32'hDEAD_BEEF, 1, "R10 bypass store");
        acc(2'b00, 0, 32'h1234_5678, 0, "R10 bypass fetch");
        xlat_en = 1;
        acc(2'b01, 1, 32'hFFFF_E000, 1, "R9 R8 refuse after set");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule